// File: doc/BRIEF.md
# I2C Current-Setpoint Slave

This block is the serial control front end of a programmable current-sink driver. A bus master writes an 8-bit code over a two-wire I2C link, and that code becomes the setpoint of a current DAC. The sink current is the code times 500 µA. A code of zero turns the sink off. The block has no readback: it is write-only, and every data byte that follows an accepted address goes straight into the setpoint register, without a sub-address.

Both bus lines are brought into the system clock domain through a two-flop synchroniser. START and STOP are recognised on the synchronised copies, which needs a system clock at least eight times the SCL rate. Two strap pins choose one of four device addresses. The block acknowledges only a matching address with the write direction. It drives SDA through an open-drain pull-low output. A supply-fault input clears the setpoint. An active-low sleep input holds all the logic in reset, so the output stays off.

Top module: `isink_setpoint_i2c`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START in any state begins a new address byte.
- R2: The expected address byte, with its direction bit 0 in bit 0, is 0x18 + 2·addrSel. When the address matches, sdaPullLow goes high after the eighth SCL falling edge and returns low after the ninth. It does not change while SCL stays high.
- R3: An address that does not match is not acknowledged, and neither is any byte with bit 0 = 1 (read). The same holds for bits clocked while no transfer is open after STOP. In all these cases the following bytes are not acknowledged either, and the setpoint keeps its value until the next START.
- R4: Once an address is acknowledged, every received byte (MSB first) is loaded into the setpoint and acknowledged in the following clock. Any number of bytes may come before STOP.
- R5: A START or STOP before the eighth bit of a data byte ends the transfer and leaves the setpoint unchanged. After a repeated START the address is expected again. The setpoint changes only on a complete byte or a fault.
- R6: sinkEnable is 1 exactly when the setpoint is nonzero.
- R7: With rstN low, the setpoint is 0 and sdaPullLow is 0. A faultIn high at a clock edge makes the setpoint 0 from the next edge on, and faultIn takes priority over a byte load.
- R8: While sleepN is low, the setpoint is 0, sinkEnable is 0 and sdaPullLow is 0. No bus traffic is acknowledged or takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8× the SCL rate |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| sleepN | input | 1 | Sleep, active low; holds all logic in reset |
| faultIn | input | 1 | Supply fault, active high; clears the setpoint |
| addrSel | input | 2 | Address straps; the address byte is 0x18 + 2·addrSel |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaPullLow | output | 1 | High to pull SDA low (acknowledge) |
| setpoint | output | 8 | DAC code; current = code × 500 µA |
| sinkEnable | output | 1 | Output sink on (setpoint nonzero) |

## Verification
On every cycle the assertions check four things. A fault clears the code by the next edge. Sleep keeps the code, the enable and the pull-low at zero. The pull-low never moves during a high SCL phase. The setpoint moves only on a whole-byte load strobe or a fault. Other behaviour shows only in the bench's bus scenarios, which a scoreboard compares against the expected sequence of setpoint values:
- each of the four strap addresses is accepted;
- mismatched and read addresses are refused;
- several bytes go into one transfer;
- a transfer is cut off partway through a byte by STOP or by a repeated START;
- traffic during sleep has no effect.

// File: rtl/sink_pkg.sv
package sink_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } busState_t;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic shiftBit;      // sample synchronised SDA into the shift register
    logic loadSetpoint;  // eighth data bit present: commit the byte
  } ctlStb_t;

endpackage

// File: rtl/sink_line_sync.sv
module sink_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] syncOut
);

  // idle bus level is high, so every stage resets to 1
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/sink_bus_ctrl.sv
module sink_bus_ctrl
  import sink_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclS,
  input  logic    sdaS,
  input  logic    addrHit,
  output ctlStb_t ctlStb,
  output logic    sdaPullLow
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  busState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackOn;
  logic             sclD, sdaD;
  logic             sclRise, sclFall, startSeen, stopSeen, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign lastBit   = (bitCnt == LAST_BIT);

  always_comb begin
    ctlStb.shiftBit     = sclRise && (state == ST_ADDR || state == ST_DATA);
    ctlStb.loadSetpoint = sclRise && (state == ST_DATA) && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) begin
            if (lastBit) begin
              state  <= addrHit ? ST_ADDR_ACK : ST_SKIP;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sclRise) begin
            if (lastBit) begin
              state  <= ST_DATA_ACK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          // first fall ends bit eight, second fall ends the ack clock
          if (sclFall) begin
            if (!ackOn) begin
              ackOn <= 1'b1;
            end else begin
              ackOn <= 1'b0;
              state <= ST_DATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullLow = ackOn;

endmodule

// File: rtl/sink_datapath.sv
module sink_datapath
  import sink_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter int                SEL_W     = 2,
  parameter logic [BYTE_W-2:0] ADDR_BASE = 7'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultIn,
  input  logic [SEL_W-1:0]  addrSel,
  input  logic              sdaS,
  input  ctlStb_t           ctlStb,
  output logic              addrHit,
  output logic [BYTE_W-1:0] setpoint,
  output logic              sinkEnable
);

  localparam int DEV_W = BYTE_W - 1;

  logic [DEV_W-1:0]  shiftReg;
  logic [BYTE_W-1:0] byteNow;
  logic [DEV_W-1:0]  devAddr;

  // byte as it stands once the bit now on SDA is included
  assign byteNow = {shiftReg, sdaS};
  assign devAddr = ADDR_BASE + DEV_W'(addrSel);
  assign addrHit = (byteNow == {devAddr, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (ctlStb.shiftBit) shiftReg <= byteNow[DEV_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    setpoint <= '0;
    else if (faultIn)             setpoint <= '0;
    else if (ctlStb.loadSetpoint) setpoint <= byteNow;
  end

  assign sinkEnable = |setpoint;

endmodule

// File: rtl/isink_setpoint_i2c.sv
module isink_setpoint_i2c
  import sink_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                SEL_W       = 2,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-2:0] ADDR_BASE   = 7'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepN,
  input  logic              faultIn,
  input  logic [SEL_W-1:0]  addrSel,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] setpoint,
  output logic              sinkEnable
);

  logic    coreRstN;
  logic    sclSync, sdaSync;
  logic    addrHit;
  ctlStb_t ctlStb;

  // sleep holds everything in the same state as power-up
  assign coreRstN = rstN & sleepN;

  sink_line_sync #(
    .LINES (2),
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk    (clk),
    .rstN   (coreRstN),
    .rawIn  ({sclIn, sdaIn}),
    .syncOut({sclSync, sdaSync})
  );

  sink_bus_ctrl #(
    .BYTE_W(BYTE_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (coreRstN),
    .sclS      (sclSync),
    .sdaS      (sdaSync),
    .addrHit   (addrHit),
    .ctlStb    (ctlStb),
    .sdaPullLow(sdaPullLow)
  );

  sink_datapath #(
    .BYTE_W   (BYTE_W),
    .SEL_W    (SEL_W),
    .ADDR_BASE(ADDR_BASE)
  ) i_dp (
    .clk       (clk),
    .rstN      (coreRstN),
    .faultIn   (faultIn),
    .addrSel   (addrSel),
    .sdaS      (sdaSync),
    .ctlStb    (ctlStb),
    .addrHit   (addrHit),
    .setpoint  (setpoint),
    .sinkEnable(sinkEnable)
  );

endmodule

// File: rtl/isink_setpoint_checker.sv
module isink_setpoint_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepN,
  input logic              faultIn,
  input logic              sclSync,
  input logic              loadStb,
  input logic              sdaPullLow,
  input logic [BYTE_W-1:0] setpoint,
  input logic              sinkEnable
);

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rstN || !sleepN)
    faultIn |=> (setpoint == '0)); // R7

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !sleepN |-> (setpoint == '0 && !sinkEnable && !sdaPullLow)); // R8

  AST_ACK_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN || !sleepN)
    (sclSync && $past(sclSync)) |-> $stable(sdaPullLow)); // R2

  AST_WHOLE_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rstN || !sleepN)
    !$stable(setpoint) |-> $past(loadStb || faultIn)); // R5

endmodule

bind isink_setpoint_i2c isink_setpoint_checker #(.BYTE_W(BYTE_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sleepN    (sleepN),
  .faultIn   (faultIn),
  .sclSync   (sclSync),
  .loadStb   (ctlStb.loadSetpoint),
  .sdaPullLow(sdaPullLow),
  .setpoint  (setpoint),
  .sinkEnable(sinkEnable)
);

// File: tb/test_isink_setpoint_i2c.sv
`timescale 1ns/1ps
module test_isink_setpoint_i2c;

  localparam int Q = 6;  // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepN = 1'b1;
  logic       faultIn = 1'b0;
  logic [1:0] addrSel = 2'd0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaIn;
  logic       sdaPullLow;
  logic [7:0] setpoint;
  logic       sinkEnable;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  logic [7:0] modelSp = 8'h00;
  logic [7:0] lastSp = 8'h00;

  always #4 clk = ~clk;

  // wired-AND bus: master and slave both only pull low
  assign sdaIn = sdaM & ~sdaPullLow;

  isink_setpoint_i2c i_isink_setpoint_i2c (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .faultIn(faultIn),
    .addrSel(addrSel), .sclIn(sclM), .sdaIn(sdaIn),
    .sdaPullLow(sdaPullLow), .setpoint(setpoint), .sinkEnable(sinkEnable)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every setpoint change must match the next expected code
  always @(negedge clk) begin
    if (setpoint !== lastSp) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected setpoint change", int'(setpoint), int'(lastSp));
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(setpoint === e, "R4 setpoint sequence", int'(setpoint), int'(e));
      end
      lastSp = setpoint;
    end
  end

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic expectSp(input logic [7:0] v);
    if (v != modelSp) expQ.push_back(v);
    modelSp = v;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(1);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic ackSlot(output bit acked);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    acked = !sdaIn;
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    bit acked;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    ackSlot(acked);
    check(acked == expAck, tag, int'(acked), int'(expAck));
  endtask

  task automatic writeByte(input logic [7:0] v);
    expectSp(v);
    sendByte(v, 1'b1, "R4 data ack");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(setpoint == 8'h00, "R7 reset setpoint", int'(setpoint), 0);
    check(sdaPullLow == 1'b0, "R7 reset pull", int'(sdaPullLow), 0);
    check(sinkEnable == 1'b0, "R6 reset enable", int'(sinkEnable), 0);
    rstN = 1'b1;
    waitQ(2);

    // R2 / R4: strap 0, several bytes in one transfer
    addrSel = 2'd0;
    busStart();
    sendByte(8'h18, 1'b1, "R2 addr 0x18 ack");
    writeByte(8'h5A);
    writeByte(8'h01);
    writeByte(8'hFF);
    busStop();
    check(setpoint == 8'hFF, "R4 last byte kept", int'(setpoint), 'hFF);
    check(sinkEnable == 1'b1, "R6 enable nonzero", int'(sinkEnable), 1);

    // R2 strap 2, write zero code
    addrSel = 2'd2;
    busStart();
    sendByte(8'h1C, 1'b1, "R2 addr 0x1C ack");
    writeByte(8'h00);
    busStop();
    check(sinkEnable == 1'b0, "R6 enable zero", int'(sinkEnable), 0);
    writeOne(8'h1C, 8'h21);

    // R3 mismatched address, later byte ignored
    busStart();
    sendByte(8'h18, 1'b0, "R3 mismatch no ack");
    sendByte(8'h77, 1'b0, "R3 skipped byte");
    busStop();
    check(setpoint == 8'h21, "R3 setpoint kept", int'(setpoint), 'h21);

    // R3 read direction
    busStart();
    sendByte(8'h1D, 1'b0, "R3 read no ack");
    sendByte(8'h33, 1'b0, "R3 read byte skipped");
    busStop();

    // R3 bits with no START after a STOP
    sendByte(8'h1C, 1'b0, "R3 no start no ack");
    check(setpoint == 8'h21, "R3 idle bits ignored", int'(setpoint), 'h21);

    // R5 STOP in the middle of a data byte
    busStart();
    sendByte(8'h1C, 1'b1, "R2 addr ack before abort");
    writeByte(8'h40);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    check(setpoint == 8'h40, "R5 partial byte after stop", int'(setpoint), 'h40);

    // R5 / R1 repeated START in the middle of a data byte
    busStart();
    sendByte(8'h1C, 1'b1, "R1 addr ack");
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    busStart();
    sendByte(8'h1C, 1'b1, "R1 readdress after restart");
    writeByte(8'h81);
    busStop();
    check(setpoint == 8'h81, "R5 byte after restart", int'(setpoint), 'h81);

    // R2 remaining straps
    addrSel = 2'd3;
    writeOne(8'h1E, 8'h22);
    addrSel = 2'd1;
    writeOne(8'h1A, 8'h10);
    busStart();
    sendByte(8'h1E, 1'b0, "R2 other strap refused");
    busStop();

    // R7 fault clears
    expectSp(8'h00);
    faultIn = 1'b1;
    @(negedge clk);
    faultIn = 1'b0;
    @(negedge clk);
    check(setpoint == 8'h00, "R7 fault clears", int'(setpoint), 0);
    check(sinkEnable == 1'b0, "R7 fault disables", int'(sinkEnable), 0);

    // R8 sleep
    writeOne(8'h1A, 8'h66);
    expectSp(8'h00);
    sleepN = 1'b0;
    waitQ(1);
    check(setpoint == 8'h00, "R8 sleep clears", int'(setpoint), 0);
    check(sinkEnable == 1'b0, "R8 sleep disables", int'(sinkEnable), 0);
    busStart();
    sendByte(8'h1A, 1'b0, "R8 no ack in sleep");
    sendByte(8'h44, 1'b0, "R8 no data ack in sleep");
    busStop();
    check(setpoint == 8'h00, "R8 traffic ignored", int'(setpoint), 0);
    sleepN = 1'b1;
    waitQ(2);
    writeOne(8'h1A, 8'h3C);
    check(setpoint == 8'h3C, "R8 works after wake", int'(setpoint), 'h3C);

    waitQ(2);
    check(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic writeOne(input logic [7:0] addrByte, input logic [7:0] v);
    busStart();
    sendByte(addrByte, 1'b1, "R2 addr ack");
    writeByte(v);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule